// File: doc/BRIEF.md
# Nested interrupt priority resolver

This block arbitrates eight level-sensitive interrupt lines for a single interrupt controller. Each clock it copies the lines into a request register. Requests that are pending and not masked are compared against the in-service register, and the block raises a registered interrupt output whenever some request may pre-empt the level now being serviced. Priority is fixed: line 0 is the highest and the last line is the lowest.

An acknowledge pulse moves the current winner from the request register into the in-service register and reports the winner's index for one cycle. A non-specific end-of-interrupt pulse retires the highest-priority level in service. The in-service register is always visible on a port, so software can tell when it has emptied.

A mode input chooses between two nesting rules. In normal nesting, a level that is in service blocks itself and every lower level. In special nesting, the level in service may be requested again. A cascaded slave can therefore pass on a second, higher request from inside its own group while its first one is still being serviced.

Top module: `nest_irq_resolver`

## Requirements
- R1: After synchronous reset, in_service is all zeros, irq_out is 0, ack_valid is 0 and the mask register is all zeros (every line unmasked).
- R2: Lines are sampled into the request register on every clock edge. An unmasked line raised while nothing is in service sets irq_out after that same edge, and irq_out clears after the edge that samples the line low.
- R3: The mask register is loaded from mask_data on an edge where mask_wr is 1. A line whose mask bit is 1 never causes irq_out, and it causes irq_out again after the edge that clears its mask bit.
- R4: On acknowledge, the eligible request with the lowest index wins, and its index appears on ack_id.
- R5: On an edge with ack at 1 and an eligible request present, bit ack_id of in_service is set, the winner's request bit is cleared, and ack_valid is 1 for the following cycle. If no request is eligible, ack leaves in_service unchanged and ack_valid stays 0.
- R6: With special_nest at 0, a line whose in-service bit is set blocks new requests from itself and from every lower-priority line. A line of higher priority still raises irq_out.
- R7: With special_nest at 1, a request on the highest-priority level already in service is eligible again, and lower-priority lines remain blocked.
- R8: An eoi pulse clears exactly the lowest-index set bit of in_service. With in_service empty, eoi has no effect.
- R9: When ack and eoi arrive on the same edge, the clear acts on the in-service register held before the edge and the winner's bit is then set. If both name the same bit, that bit ends up set.
- R10: irq_out is a register that reflects the request, mask and in-service state after the edge. It drops after an acknowledge edge when nothing else is eligible.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_lines | input | NUM_LINES | Level-sensitive interrupt lines, bit 0 highest priority |
| mask_wr | input | 1 | Load strobe for the mask register |
| mask_data | input | NUM_LINES | New mask value; a 1 masks the line |
| special_nest | input | 1 | 0 selects normal nesting, 1 selects special nesting |
| ack | input | 1 | Acknowledge pulse; moves the winner into service |
| eoi | input | 1 | Non-specific end-of-interrupt pulse |
| irq_out | output | 1 | Registered interrupt request to the processor |
| ack_valid | output | 1 | One-cycle flag that the last ack granted a line |
| ack_id | output | ID_W | Index of the granted line, valid with ack_valid |
| in_service | output | NUM_LINES | In-service register readback |

## Verification
An acknowledge and an end-of-interrupt can land on the same edge. The bench drives them together in three situations. In the first, both target the same level while special nesting is active. In the second, the retired level differs from the granted one. In the third, the in-service register is empty, so the end-of-interrupt has nothing to clear. Each case is judged on the in-service value, the reported index and the interrupt output one cycle later. The expected result is that the clear uses the old register contents and the grant's set bit wins.

// File: rtl/irq_res_pkg.sv
package irq_res_pkg;

  typedef enum logic {
    NEST_NORMAL  = 1'b0,
    NEST_SPECIAL = 1'b1
  } nest_mode_e;

endpackage

// File: rtl/irq_first_set.sv
module irq_first_set #(
  parameter int W = 8
) (
  input  logic [W-1:0] vec,
  output logic [W-1:0] onehot,
  output logic         any
);
  // prefix chain: seen[i] is high when some lower-index bit is set
  logic [W:0] seen;

  assign seen[0] = 1'b0;

  for (genvar i = 0; i < W; i++) begin : g_chain
    assign onehot[i]  = vec[i] & ~seen[i];
    assign seen[i+1]  = seen[i] | vec[i];
  end

  assign any = seen[W];

endmodule

// File: rtl/irq_eligible.sv
module irq_eligible
  import irq_res_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] pend,
  input  logic [W-1:0] isr,
  input  nest_mode_e   mode,
  output logic [W-1:0] elig
);
  logic [W-1:0] clear_above;
  logic [W-1:0] top_isr;
  logic [W-1:0] allowed;

  for (genvar i = 0; i < W; i++) begin : g_lvl
    if (i == 0) begin : g_first
      assign clear_above[i] = 1'b1;
    end else begin : g_rest
      assign clear_above[i] = ~|isr[i-1:0];
    end
    // highest-priority level currently in service
    assign top_isr[i] = isr[i] & clear_above[i];
    // strictly above everything in service, or same level in special mode
    assign allowed[i] = (clear_above[i] & ~isr[i]) |
                        ((mode == NEST_SPECIAL) & top_isr[i]);
  end

  assign elig = pend & allowed;

endmodule

// File: rtl/irq_isr_bank.sv
module irq_isr_bank #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set_oh,
  input  logic         eoi,
  output logic [W-1:0] isr_q,
  output logic [W-1:0] isr_next
);
  logic [W-1:0] lowest;

  for (genvar i = 0; i < W; i++) begin : g_low
    if (i == 0) begin : g_first
      assign lowest[i] = isr_q[i];
    end else begin : g_rest
      assign lowest[i] = isr_q[i] & ~|isr_q[i-1:0];
    end
  end

  // clear works on the old contents; a grant set takes precedence
  assign isr_next = (isr_q & ~(eoi ? lowest : '0)) | set_oh;

  always_ff @(posedge clk) begin
    if (rst) isr_q <= '0;
    else     isr_q <= isr_next;
  end

endmodule

// File: rtl/nest_irq_resolver.sv
module nest_irq_resolver
  import irq_res_pkg::*;
#(
  parameter int NUM_LINES = 8,
  localparam int ID_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_LINES-1:0] irq_lines,
  input  logic                 mask_wr,
  input  logic [NUM_LINES-1:0] mask_data,
  input  logic                 special_nest,
  input  logic                 ack,
  input  logic                 eoi,
  output logic                 irq_out,
  output logic                 ack_valid,
  output logic [ID_W-1:0]      ack_id,
  output logic [NUM_LINES-1:0] in_service
);
  nest_mode_e           mode;
  logic [NUM_LINES-1:0] req_q, mask_q, isr_q;
  logic [NUM_LINES-1:0] elig_now, win_oh, set_oh;
  logic [NUM_LINES-1:0] req_next, mask_next, isr_next, elig_next;
  logic                 win_any, grant;
  logic [ID_W-1:0]      win_idx;
  logic                 intr_q, avalid_q;
  logic [ID_W-1:0]      aid_q;

  assign mode = special_nest ? NEST_SPECIAL : NEST_NORMAL;

  irq_eligible #(.W(NUM_LINES)) u_elig_now (
    .pend (req_q & ~mask_q),
    .isr  (isr_q),
    .mode (mode),
    .elig (elig_now)
  );

  irq_first_set #(.W(NUM_LINES)) u_pick (
    .vec    (elig_now),
    .onehot (win_oh),
    .any    (win_any)
  );

  always_comb begin
    win_idx = '0;
    for (int i = 0; i < NUM_LINES; i++) begin
      if (win_oh[i]) win_idx = ID_W'(i);
    end
  end

  assign grant     = ack & win_any;
  assign set_oh    = grant ? win_oh : '0;
  assign req_next  = irq_lines & ~set_oh;
  assign mask_next = mask_wr ? mask_data : mask_q;

  irq_isr_bank #(.W(NUM_LINES)) u_isr (
    .clk      (clk),
    .rst      (rst),
    .set_oh   (set_oh),
    .eoi      (eoi),
    .isr_q    (isr_q),
    .isr_next (isr_next)
  );

  // interrupt output looks at the post-edge state so it never lags a grant
  irq_eligible #(.W(NUM_LINES)) u_elig_next (
    .pend (req_next & ~mask_next),
    .isr  (isr_next),
    .mode (mode),
    .elig (elig_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q    <= '0;
      mask_q   <= '0;
      intr_q   <= 1'b0;
      avalid_q <= 1'b0;
      aid_q    <= '0;
    end else begin
      req_q    <= req_next;
      mask_q   <= mask_next;
      intr_q   <= |elig_next;
      avalid_q <= grant;
      if (grant) aid_q <= win_idx;
    end
  end

  assign irq_out    = intr_q;
  assign ack_valid  = avalid_q;
  assign ack_id     = aid_q;
  assign in_service = isr_q;

endmodule

// File: rtl/irq_resolver_chk.sv
module irq_resolver_chk #(
  parameter int NUM_LINES = 8,
  localparam int ID_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 ack,
  input logic                 eoi,
  input logic                 irq_out,
  input logic                 ack_valid,
  input logic [ID_W-1:0]      ack_id,
  input logic [NUM_LINES-1:0] in_service
);
  logic [NUM_LINES-1:0] above_id;

  always_comb begin
    for (int i = 0; i < NUM_LINES; i++) begin
      above_id[i] = (ID_W'(i) < ack_id);
    end
  end

  // R1
  reset_clears_chk: assert property (@(posedge clk)
    rst |=> (in_service == '0) && !irq_out && !ack_valid);

  // R5
  grant_needs_ack_chk: assert property (@(posedge clk) disable iff (rst)
    ack_valid |-> $past(ack));

  // R5
  grant_in_service_chk: assert property (@(posedge clk) disable iff (rst)
    ack_valid |-> in_service[ack_id]);

  // R4
  grant_top_level_chk: assert property (@(posedge clk) disable iff (rst)
    ack_valid |-> ((in_service & above_id) == '0));

  // R8
  eoi_empty_chk: assert property (@(posedge clk) disable iff (rst)
    (eoi && !ack && in_service == '0) |=> (in_service == '0));

  // R8
  eoi_one_bit_chk: assert property (@(posedge clk) disable iff (rst)
    (eoi && !ack && in_service != '0) |=>
      ($countones(in_service) + 1 == $past($countones(in_service))));

endmodule

bind nest_irq_resolver irq_resolver_chk #(.NUM_LINES(NUM_LINES)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .ack        (ack),
  .eoi        (eoi),
  .irq_out    (irq_out),
  .ack_valid  (ack_valid),
  .ack_id     (ack_id),
  .in_service (in_service)
);

// File: tb/nest_irq_resolver_tb.sv
module nest_irq_resolver_tb;

  logic       clk = 1'b0;
  logic       rst;
  logic [7:0] irq_lines;
  logic       mask_wr;
  logic [7:0] mask_data;
  logic       special_nest;
  logic       ack, eoi;
  logic       irq_out, ack_valid;
  logic [2:0] ack_id;
  logic [7:0] in_service;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  typedef struct {
    logic       intr;
    logic [7:0] isr;
    logic       idv;
    logic [2:0] id;
    string      tag;
  } exp_t;

  exp_t sb[$];

  always #4 clk = ~clk;

  nest_irq_resolver #(.NUM_LINES(8)) u_dut (
    .clk          (clk),
    .rst          (rst),
    .irq_lines    (irq_lines),
    .mask_wr      (mask_wr),
    .mask_data    (mask_data),
    .special_nest (special_nest),
    .ack          (ack),
    .eoi          (eoi),
    .irq_out      (irq_out),
    .ack_valid    (ack_valid),
    .ack_id       (ack_id),
    .in_service   (in_service)
  );

  // monitor: pops one expectation per cycle, away from the rising edge
  always @(negedge clk) begin
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      total++;
      if (irq_out !== e.intr || in_service !== e.isr || ack_valid !== e.idv ||
          (e.idv && ack_id !== e.id)) begin
        bad++;
        $display("FAIL %s: got intr=%b isr=%h avalid=%b id=%0d, exp intr=%b isr=%h avalid=%b id=%0d",
                 e.tag, irq_out, in_service, ack_valid, ack_id,
                 e.intr, e.isr, e.idv, e.id);
      end
    end
  end

  // driver: apply one cycle of stimulus and queue the expected outcome
  task automatic step(input logic [7:0] ln, input logic mw, input logic [7:0] md,
                      input logic a, input logic e,
                      input logic x_intr, input logic [7:0] x_isr,
                      input logic x_idv, input logic [2:0] x_id, input string tag);
    exp_t x;
    irq_lines = ln;
    mask_wr   = mw;
    mask_data = md;
    ack       = a;
    eoi       = e;
    @(posedge clk);
    x.intr = x_intr; x.isr = x_isr; x.idv = x_idv; x.id = x_id; x.tag = tag;
    sb.push_back(x);
    @(negedge clk);
  endtask

  initial begin
    rst = 1'b1; irq_lines = '0; mask_wr = 1'b0; mask_data = '0;
    special_nest = 1'b0; ack = 1'b0; eoi = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1 reset state, then prove mask is clear: an unmasked line raises irq_out
    step(8'h00, 0, 8'h00, 0, 0, 0, 8'h00, 0, 0, "R1");
    step(8'h08, 0, 8'h00, 0, 0, 1, 8'h00, 0, 0, "R1_R2");
    step(8'h00, 0, 8'h00, 0, 0, 0, 8'h00, 0, 0, "R2");
    // R3 masking
    step(8'h08, 1, 8'h08, 0, 0, 0, 8'h00, 0, 0, "R3");
    step(8'h08, 0, 8'h00, 0, 0, 0, 8'h00, 0, 0, "R3");
    step(8'h08, 1, 8'h00, 0, 0, 1, 8'h00, 0, 0, "R3");
    step(8'h28, 0, 8'h00, 0, 0, 1, 8'h00, 0, 0, "R2");
    // R4 R5 R10 acknowledge picks line 3, output drops
    step(8'h20, 0, 8'h00, 1, 0, 0, 8'h08, 1, 3, "R4_R5_R10");
    // R6 normal nesting
    step(8'h20, 0, 8'h00, 0, 0, 0, 8'h08, 0, 0, "R6");
    step(8'h28, 0, 8'h00, 0, 0, 0, 8'h08, 0, 0, "R6");
    step(8'h2A, 0, 8'h00, 0, 0, 1, 8'h08, 0, 0, "R6");
    step(8'h28, 0, 8'h00, 1, 0, 0, 8'h0A, 1, 1, "R4_R6");
    // R8 eoi retires level 1 only
    step(8'h28, 0, 8'h00, 0, 1, 0, 8'h08, 0, 0, "R8");
    // R7 special nesting re-admits level 3
    special_nest = 1'b1;
    step(8'h28, 0, 8'h00, 0, 0, 1, 8'h08, 0, 0, "R7");
    // R9 same-level ack and eoi together
    step(8'h20, 0, 8'h00, 1, 1, 0, 8'h08, 1, 3, "R9");
    step(8'h20, 0, 8'h00, 0, 1, 1, 8'h00, 0, 0, "R8");
    step(8'h00, 0, 8'h00, 1, 0, 0, 8'h20, 1, 5, "R5");
    step(8'h04, 0, 8'h00, 0, 1, 1, 8'h00, 0, 0, "R8");
    // R9 ack with eoi on an empty register
    step(8'h00, 0, 8'h00, 1, 1, 0, 8'h04, 1, 2, "R9");
    step(8'h00, 0, 8'h00, 0, 1, 0, 8'h00, 0, 0, "R8");
    step(8'h00, 0, 8'h00, 0, 1, 0, 8'h00, 0, 0, "R8");
    // R5 ack with nothing eligible
    step(8'h00, 0, 8'h00, 1, 0, 0, 8'h00, 0, 0, "R5");
    // R9 ack and eoi on different levels
    step(8'h40, 0, 8'h00, 0, 0, 1, 8'h00, 0, 0, "R7");
    step(8'h10, 0, 8'h00, 1, 0, 1, 8'h40, 1, 6, "R6_R10");
    step(8'h00, 0, 8'h00, 1, 1, 0, 8'h10, 1, 4, "R9");
    step(8'h00, 0, 8'h00, 0, 1, 0, 8'h00, 0, 0, "R8");
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: got hang, exp completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule